// File: doc/BRIEF.md
# Framed SPI Register Slave

This block is the device end of a multi-drop register link. Up to 32 chips share one SPI bus (mode 0, 8-bit bytes, most significant bit first) and one chip select. Every frame opens with a four-byte header. The first header byte names the target chip. The second byte holds a direction flag and a register address. The last two bytes give the number of payload bytes. Only the chip whose strapped id matches the header takes part in the frame. All other chips leave their data-out line high, so the host reads 0xFF from them.

Registers are 32 bits wide and are carried least significant byte first. A long payload walks through consecutive registers, four bytes each. Two registers live inside the block: a fixed identification word at address 0 and a status word at address 1 that reports the core count. All higher addresses are served through a small synchronous register bus towards the rest of the chip. A write reaches that bus only as a whole word, after its fourth byte has arrived. The SPI pins are oversampled by the system clock, so every SCK phase must last at least four system clock periods.

Top module: `spi_reg_slave`

## Requirements
- R1: The first header byte must equal {3'b000, chip_id}. Otherwise the frame is ignored: spi_miso stays 1 and no bus access happens. This includes ids above 0x1F.
- R2: Bit 7 of the second header byte selects a read when 1 and a write when 0. Bits 6:0 give the starting register address. During a write frame spi_miso stays 1.
- R3: In a read, each payload byte is shifted out most significant bit first. spi_miso changes only after SCK falling edges. The register bytes come in order from byte 0 (bits 7:0) to byte 3 (bits 31:24).
- R4: Address 0x00 reads as the bytes 0x44, 0x8A, 0xAC, 0xB1, in that order. Writes to address 0x00 raise no bus write strobe and leave it unchanged.
- R5: Address 0x01 reads as the bytes 0x00, 0x00, NUM_CORES, 0x00. Writes to it raise no bus write strobe.
- R6: The third and fourth header bytes form a 16-bit payload length, low byte first. In a read, slots past the length return 0xFF. In a write, bytes past the length are discarded.
- R7: After every four payload bytes the register address advances by one, wrapping from 0x7F to 0x00.
- R8: A write raises bus_wr_en for exactly one cycle once the fourth byte of a register has arrived. At that time bus_addr holds the register address and bus_wdata holds the four bytes, the first byte in bits 7:0. A register with fewer than four bytes in the frame is never written.
- R9: Raising spi_cs_n ends the frame, discards any partial word and forces spi_miso to 1. spi_miso is also 1 during all header bytes.
- R10: For a read of an address of 2 or more, bus_rd_en pulses for one cycle with bus_addr set, and bus_rd_data is taken in that same cycle. bus_rd_en and bus_wr_en are never high together.
- R11: While rst is high and after it is released, spi_miso is 1 and both bus strobes are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, also used to oversample the SPI pins |
| rst | input | 1 | Synchronous active-high reset |
| chip_id | input | 5 | Strapped id of this chip on the shared bus |
| spi_sck | input | 1 | SPI serial clock, idle low |
| spi_cs_n | input | 1 | Shared chip select, active low |
| spi_mosi | input | 1 | Host-to-device serial data |
| spi_miso | output | 1 | Device-to-host serial data, 1 when not driving |
| bus_rd_en | output | 1 | One-cycle read request to chip registers |
| bus_wr_en | output | 1 | One-cycle write commit to chip registers |
| bus_addr | output | 7 | Register address for the bus request |
| bus_wdata | output | 32 | Assembled write word |
| bus_rd_data | input | 32 | Read word, valid in the cycle of bus_rd_en |

## Verification
The bench builds the block with NUM_CORES = 44, so the core count in status byte 2 (0x2C) cannot be mistaken for zero or for a filler byte. It uses the default two-stage pin synchronizer, with SCK phases of eight system clocks. A strapped id of 0x13 makes both a neighbouring id and the same id with bit 5 set useful as foreign chips. Bursts starting at 0x7F reach the address wrap into the internal identification word. Writes of six bytes and frames cut off after three payload bytes exercise the discarding of partial words.

// File: rtl/spi_regs_pkg.sv
package spi_regs_pkg;

    localparam int ID_W      = 5;
    localparam int ADDR_W    = 7;
    localparam int LEN_W     = 16;
    localparam int BYTE_W    = 8;
    localparam int LANES     = 4;
    localparam int WORD_W    = LANES * BYTE_W;
    localparam int LANE_W    = $clog2(LANES);
    localparam int BIT_W     = $clog2(BYTE_W);
    localparam int PROT_REGS = 2;

    localparam logic [WORD_W-1:0] IDENT_WORD = 32'hB1AC_8A44;

    typedef enum logic [2:0] {
        PH_ID,
        PH_ADDR,
        PH_LEN_LO,
        PH_LEN_HI,
        PH_DATA
    } frame_phase_e;

    typedef struct packed {
        logic              id_ok;
        logic              is_read;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  len;
    } frame_hdr_t;

    function automatic logic [WORD_W-1:0] status_word(input logic [BYTE_W-1:0] cores);
        return {8'h00, cores, 16'h0000};
    endfunction

    // Position of the outgoing bit: lane selects the byte, MSB sent first.
    function automatic logic [LANE_W+BIT_W-1:0] tx_index(input logic [LANE_W-1:0] lane,
                                                         input logic [BIT_W-1:0]  sent);
        return {lane, ~sent};
    endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sck_pin,
    input  logic cs_n_pin,
    input  logic mosi_pin,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_active,
    output logic mosi_bit
);
    localparam int TAP = STAGES - 1;

    logic [STAGES-1:0] sck_p;
    logic [STAGES-1:0] cs_p;
    logic [STAGES-1:0] mosi_p;
    logic              sck_last;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) begin
                    sck_p  <= '0;
                    cs_p   <= '1;
                    mosi_p <= '0;
                end else begin
                    sck_p  <= sck_pin;
                    cs_p   <= cs_n_pin;
                    mosi_p <= mosi_pin;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) begin
                    sck_p  <= '0;
                    cs_p   <= '1;
                    mosi_p <= '0;
                end else begin
                    sck_p  <= {sck_p[STAGES-2:0], sck_pin};
                    cs_p   <= {cs_p[STAGES-2:0], cs_n_pin};
                    mosi_p <= {mosi_p[STAGES-2:0], mosi_pin};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) sck_last <= 1'b0;
        else     sck_last <= sck_p[TAP];
    end

    assign cs_active = ~cs_p[TAP];
    assign sck_rise  = cs_active & sck_p[TAP] & ~sck_last;
    assign sck_fall  = cs_active & ~sck_p[TAP] & sck_last;
    assign mosi_bit  = mosi_p[TAP];

endmodule

// File: rtl/spi_frame_ctrl.sv
module spi_frame_ctrl
    import spi_regs_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sck_rise,
    input  logic                 cs_active,
    input  logic                 mosi_bit,
    input  logic [ID_W-1:0]      chip_id,
    output logic                 fetch,
    output logic [ADDR_W-1:0]    fetch_addr,
    output logic                 wr_stb,
    output logic [ADDR_W-1:0]    wr_addr,
    output logic [WORD_W-1:0]    wr_data,
    output logic                 tx_en,
    output logic [LANE_W-1:0]    tx_lane,
    output logic [BIT_W-1:0]     bit_cnt
);
    localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(LANES - 1);

    frame_phase_e       phase;
    frame_hdr_t         hdr;
    logic [BYTE_W-1:0]  shreg;
    logic [LEN_W-1:0]   dcnt;
    logic [WORD_W-1:0]  wbuf;

    logic [BYTE_W-1:0]  byte_nx;
    logic               byte_done;
    logic               in_len;
    logic               more_after;
    logic [LANE_W-1:0]  lane;
    logic [LEN_W:0]     dnext;

    assign byte_nx    = {shreg[BYTE_W-2:0], mosi_bit};
    assign byte_done  = sck_rise && (bit_cnt == BIT_W'(BYTE_W - 1));
    assign in_len     = dcnt < hdr.len;
    assign lane       = dcnt[LANE_W-1:0];
    assign dnext      = {1'b0, dcnt} + 1'b1;
    assign more_after = dnext < {1'b0, hdr.len};

    always_ff @(posedge clk) begin
        if (rst || !cs_active) begin
            phase   <= PH_ID;
            hdr     <= '0;
            shreg   <= '0;
            bit_cnt <= '0;
            dcnt    <= '0;
            wbuf    <= '0;
            fetch   <= 1'b0;
            wr_stb  <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            fetch  <= 1'b0;
            wr_stb <= 1'b0;
            if (sck_rise) begin
                shreg   <= byte_nx;
                bit_cnt <= bit_cnt + 1'b1;
            end
            if (byte_done) begin
                unique case (phase)
                    PH_ID: begin
                        hdr.id_ok <= (byte_nx == {{(BYTE_W-ID_W){1'b0}}, chip_id});
                        phase     <= PH_ADDR;
                    end
                    PH_ADDR: begin
                        hdr.is_read <= byte_nx[BYTE_W-1];
                        hdr.addr    <= byte_nx[ADDR_W-1:0];
                        phase       <= PH_LEN_LO;
                    end
                    PH_LEN_LO: begin
                        hdr.len[BYTE_W-1:0] <= byte_nx;
                        phase               <= PH_LEN_HI;
                    end
                    PH_LEN_HI: begin
                        hdr.len[LEN_W-1:BYTE_W] <= byte_nx;
                        phase <= PH_DATA;
                        fetch <= hdr.id_ok && hdr.is_read &&
                                 ({byte_nx, hdr.len[BYTE_W-1:0]} != '0);
                    end
                    PH_DATA: begin
                        if (in_len) begin
                            dcnt <= dnext[LEN_W-1:0];
                            if (lane == LAST_LANE)
                                hdr.addr <= hdr.addr + 1'b1;
                            if (hdr.id_ok && !hdr.is_read) begin
                                if (lane == LAST_LANE) begin
                                    wr_stb  <= 1'b1;
                                    wr_addr <= hdr.addr;
                                    wr_data <= {byte_nx, wbuf[WORD_W-BYTE_W-1:0]};
                                end else begin
                                    wbuf[lane*BYTE_W +: BYTE_W] <= byte_nx;
                                end
                            end
                            if (hdr.id_ok && hdr.is_read && lane == LAST_LANE && more_after)
                                fetch <= 1'b1;
                        end
                    end
                    default: phase <= PH_ID;
                endcase
            end
        end
    end

    assign fetch_addr = hdr.addr;
    assign tx_en      = (phase == PH_DATA) && hdr.id_ok && hdr.is_read && in_len;
    assign tx_lane    = lane;

    AST_WR_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> !wr_stb);                                                  // R8
    AST_WR_AT_BYTE_END: assert property (@(posedge clk) disable iff (rst)
        $rose(wr_stb) |-> $past(sck_rise));                                   // R8
    AST_FETCH_ONLY_READ: assert property (@(posedge clk) disable iff (rst)
        fetch |-> (tx_en && tx_lane == '0));                                  // R7

endmodule

// File: rtl/spi_tx_path.sv
module spi_tx_path
    import spi_regs_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sck_fall,
    input  logic                 cs_active,
    input  logic                 tx_en,
    input  logic [LANE_W-1:0]    tx_lane,
    input  logic [BIT_W-1:0]     bit_cnt,
    input  logic [WORD_W-1:0]    rd_word,
    output logic                 miso
);
    always_ff @(posedge clk) begin
        if (rst || !cs_active)
            miso <= 1'b1;
        else if (sck_fall)
            miso <= tx_en ? rd_word[tx_index(tx_lane, bit_cnt)] : 1'b1;
    end

    AST_MISO_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
        !cs_active |=> miso);                                                 // R9
    AST_MISO_CHANGES_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        (cs_active && !sck_fall) |=> $stable(miso));                          // R3

endmodule

// File: rtl/spi_reg_window.sv
module spi_reg_window
    import spi_regs_pkg::*;
#(
    parameter int NUM_CORES = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 fetch,
    input  logic [ADDR_W-1:0]    fetch_addr,
    input  logic                 wr_stb,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [WORD_W-1:0]    wr_data,
    input  logic [WORD_W-1:0]    bus_rd_data,
    output logic [WORD_W-1:0]    rd_word,
    output logic                 bus_rd_en,
    output logic                 bus_wr_en,
    output logic [ADDR_W-1:0]    bus_addr,
    output logic [WORD_W-1:0]    bus_wdata
);
    localparam logic [ADDR_W-1:0]  FIRST_EXT = ADDR_W'(PROT_REGS);
    localparam logic [BYTE_W-1:0]  CORES_B   = BYTE_W'(NUM_CORES);
    localparam logic [WORD_W-1:0]  STAT_WORD = status_word(CORES_B);

    assign bus_rd_en = fetch && (fetch_addr >= FIRST_EXT);
    assign bus_wr_en = wr_stb && (wr_addr >= FIRST_EXT);
    assign bus_addr  = wr_stb ? wr_addr : fetch_addr;
    assign bus_wdata = wr_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_word <= '1;
        end else if (fetch) begin
            if (fetch_addr == '0)
                rd_word <= IDENT_WORD;
            else if (fetch_addr == ADDR_W'(1))
                rd_word <= STAT_WORD;
            else
                rd_word <= bus_rd_data;
        end
    end

    AST_BUS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(bus_rd_en && bus_wr_en));                                           // R10
    AST_IDENT_LOADED: assert property (@(posedge clk) disable iff (rst)
        (fetch && fetch_addr == '0) |=> (rd_word == IDENT_WORD));             // R4
    AST_STATUS_LOADED: assert property (@(posedge clk) disable iff (rst)
        (fetch && fetch_addr == ADDR_W'(1)) |=> (rd_word[23:16] == CORES_B)); // R5

endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
    import spi_regs_pkg::*;
#(
    parameter int NUM_CORES   = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ID_W-1:0]      chip_id,
    input  logic                 spi_sck,
    input  logic                 spi_cs_n,
    input  logic                 spi_mosi,
    output logic                 spi_miso,
    output logic                 bus_rd_en,
    output logic                 bus_wr_en,
    output logic [ADDR_W-1:0]    bus_addr,
    output logic [WORD_W-1:0]    bus_wdata,
    input  logic [WORD_W-1:0]    bus_rd_data
);
    logic                sck_rise;
    logic                sck_fall;
    logic                cs_active;
    logic                mosi_bit;
    logic                fetch;
    logic [ADDR_W-1:0]   fetch_addr;
    logic                wr_stb;
    logic [ADDR_W-1:0]   wr_addr;
    logic [WORD_W-1:0]   wr_data;
    logic                tx_en;
    logic [LANE_W-1:0]   tx_lane;
    logic [BIT_W-1:0]    bit_cnt;
    logic [WORD_W-1:0]   rd_word;

    spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .sck_pin   (spi_sck),
        .cs_n_pin  (spi_cs_n),
        .mosi_pin  (spi_mosi),
        .sck_rise  (sck_rise),
        .sck_fall  (sck_fall),
        .cs_active (cs_active),
        .mosi_bit  (mosi_bit)
    );

    spi_frame_ctrl u_frame (
        .clk        (clk),
        .rst        (rst),
        .sck_rise   (sck_rise),
        .cs_active  (cs_active),
        .mosi_bit   (mosi_bit),
        .chip_id    (chip_id),
        .fetch      (fetch),
        .fetch_addr (fetch_addr),
        .wr_stb     (wr_stb),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .tx_en      (tx_en),
        .tx_lane    (tx_lane),
        .bit_cnt    (bit_cnt)
    );

    spi_reg_window #(.NUM_CORES(NUM_CORES)) u_window (
        .clk         (clk),
        .rst         (rst),
        .fetch       (fetch),
        .fetch_addr  (fetch_addr),
        .wr_stb      (wr_stb),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .bus_rd_data (bus_rd_data),
        .rd_word     (rd_word),
        .bus_rd_en   (bus_rd_en),
        .bus_wr_en   (bus_wr_en),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata)
    );

    spi_tx_path u_tx (
        .clk       (clk),
        .rst       (rst),
        .sck_fall  (sck_fall),
        .cs_active (cs_active),
        .tx_en     (tx_en),
        .tx_lane   (tx_lane),
        .bit_cnt   (bit_cnt),
        .rd_word   (rd_word),
        .miso      (spi_miso)
    );

    AST_NO_WRITE_PROTECTED: assert property (@(posedge clk) disable iff (rst)
        bus_wr_en |-> (bus_addr >= ADDR_W'(PROT_REGS)));                      // R4
    AST_NO_STROBE_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!cs_active && $past(!cs_active)) |-> !(bus_rd_en || bus_wr_en));    // R9

endmodule

// File: tb/spi_reg_slave_tb_top.sv
`timescale 1ns/1ps
module spi_reg_slave_tb_top;
    localparam int   CORES  = 44;
    localparam int   HALF   = 40;
    localparam logic [4:0] MY_ID = 5'h13;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  chip_id = MY_ID;
    logic        spi_sck = 1'b0;
    logic        spi_cs_n = 1'b1;
    logic        spi_mosi = 1'b0;
    logic        spi_miso;
    logic        bus_rd_en;
    logic        bus_wr_en;
    logic [6:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rd_data;

    always #2.5 clk = ~clk;

    spi_reg_slave #(.NUM_CORES(CORES), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst(rst), .chip_id(chip_id),
        .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .bus_rd_en(bus_rd_en), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rd_data(bus_rd_data)
    );

    logic [31:0] mem [0:127];
    assign bus_rd_data = mem[bus_addr];

    int          n_chk = 0;
    int          n_fail = 0;
    logic [6:0]  exp_a_q[$];
    logic [31:0] exp_d_q[$];
    logic [7:0]  txb[$];
    logic [7:0]  rxb[$];

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: owns the register model and pops the expected write scoreboard.
    initial begin
        for (int i = 0; i < 128; i++) mem[i] = 32'h5A00_0000 + i * 32'h0001_0103;
        forever begin
            @(negedge clk);
            if (!rst && bus_rd_en)
                chk(bus_addr >= 7'd2, "R10 read request address", {25'b0, bus_addr}, 32'd2);
            if (!rst && bus_wr_en) begin
                if (exp_a_q.size() == 0) begin
                    chk(1'b0, "R8 unexpected write strobe", {25'b0, bus_addr}, 32'hFFFF_FFFF);
                end else begin
                    logic [6:0]  ea;
                    logic [31:0] ed;
                    ea = exp_a_q.pop_front();
                    ed = exp_d_q.pop_front();
                    chk(bus_addr == ea, "R8 write address", {25'b0, bus_addr}, {25'b0, ea});
                    chk(bus_wdata == ed, "R8 write data", bus_wdata, ed);
                end
                mem[bus_addr] = bus_wdata;
            end
        end
    end

    task automatic xfer(input int count);
        rxb.delete();
        spi_cs_n = 1'b0;
        #HALF;
        for (int i = 0; i < count; i++) begin
            logic [7:0] r;
            for (int b = 7; b >= 0; b--) begin
                spi_mosi = txb[i][b];
                #HALF;
                spi_sck = 1'b1;
                r[b] = spi_miso;
                #HALF;
                spi_sck = 1'b0;
            end
            rxb.push_back(r);
        end
        #HALF;
        spi_cs_n = 1'b1;
        spi_mosi = 1'b0;
        #(HALF * 3);
    endtask

    task automatic header(input logic [7:0] id, input bit rd, input logic [6:0] addr, input logic [15:0] len);
        txb.delete();
        txb.push_back(id);
        txb.push_back({rd, addr});
        txb.push_back(len[7:0]);
        txb.push_back(len[15:8]);
    endtask

    task automatic do_read(input logic [7:0] id, input logic [6:0] addr, input logic [15:0] len, input int slots);
        header(id, 1'b1, addr, len);
        for (int i = 0; i < slots; i++) txb.push_back(8'hFF);
        xfer(4 + slots);
    endtask

    task automatic expect_bytes(input string req, input int first, input logic [7:0] b0,
                                input logic [7:0] b1, input logic [7:0] b2, input logic [7:0] b3);
        chk(rxb[first]   == b0, req, {24'b0, rxb[first]},   {24'b0, b0});
        chk(rxb[first+1] == b1, req, {24'b0, rxb[first+1]}, {24'b0, b1});
        chk(rxb[first+2] == b2, req, {24'b0, rxb[first+2]}, {24'b0, b2});
        chk(rxb[first+3] == b3, req, {24'b0, rxb[first+3]}, {24'b0, b3});
    endtask

    task automatic expect_word(input string req, input int first, input logic [31:0] w);
        expect_bytes(req, first, w[7:0], w[15:8], w[23:16], w[31:24]);
    endtask

    task automatic drain_check(input string req);
        chk(exp_a_q.size() == 0, req, exp_a_q.size(), 0);
        exp_a_q.delete();
        exp_d_q.delete();
    endtask

    initial begin
        #1_000_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] saved;
        repeat (6) @(posedge clk);
        #1;
        // R11 reset state
        chk(spi_miso == 1'b1, "R11 miso in reset", {31'b0, spi_miso}, 1);
        chk(!bus_wr_en && !bus_rd_en, "R11 strobes in reset", {30'b0, bus_rd_en, bus_wr_en}, 0);
        rst = 1'b0;
        repeat (4) @(posedge clk);
        #1;
        chk(spi_miso == 1'b1, "R11 miso after reset", {31'b0, spi_miso}, 1);

        // R4 / R3 identification word, R9 header slots high
        do_read({3'b0, MY_ID}, 7'h00, 16'd4, 4);
        expect_bytes("R9 header bytes high", 0, 8'hFF, 8'hFF, 8'hFF, 8'hFF);
        expect_bytes("R4 R3 identification bytes", 4, 8'h44, 8'h8A, 8'hAC, 8'hB1);

        // R5 status
        do_read({3'b0, MY_ID}, 7'h01, 16'd4, 4);
        expect_bytes("R5 status bytes", 4, 8'h00, 8'h00, 8'(CORES), 8'h00);

        // R10 external read
        saved = mem[7'h22];
        do_read({3'b0, MY_ID}, 7'h22, 16'd4, 4);
        expect_word("R10 external read", 4, saved);

        // R8 single write, then read back
        header({3'b0, MY_ID}, 1'b0, 7'h22, 16'd4);
        txb.push_back(8'h11); txb.push_back(8'h22); txb.push_back(8'h33); txb.push_back(8'h44);
        exp_a_q.push_back(7'h22); exp_d_q.push_back(32'h4433_2211);
        xfer(8);
        drain_check("R8 single write strobe");
        do_read({3'b0, MY_ID}, 7'h22, 16'd4, 4);
        expect_bytes("R8 readback", 4, 8'h11, 8'h22, 8'h33, 8'h44);

        // R7 burst write over two registers, burst read back
        header({3'b0, MY_ID}, 1'b0, 7'h30, 16'd8);
        for (int i = 0; i < 8; i++) txb.push_back(8'(8'hC0 + i));
        exp_a_q.push_back(7'h30); exp_d_q.push_back(32'hC3C2_C1C0);
        exp_a_q.push_back(7'h31); exp_d_q.push_back(32'hC7C6_C5C4);
        xfer(12);
        drain_check("R7 burst write strobes");
        do_read({3'b0, MY_ID}, 7'h30, 16'd8, 8);
        expect_word("R7 burst read first", 4, 32'hC3C2_C1C0);
        expect_word("R7 burst read second", 8, 32'hC7C6_C5C4);

        // R7 address wrap from 0x7F into the identification word
        saved = mem[7'h7F];
        do_read({3'b0, MY_ID}, 7'h7F, 16'd8, 8);
        expect_word("R7 wrap top register", 4, saved);
        expect_bytes("R7 wrap into address 0", 8, 8'h44, 8'h8A, 8'hAC, 8'hB1);

        // R6 short read length
        do_read({3'b0, MY_ID}, 7'h00, 16'd2, 4);
        expect_bytes("R6 slots past length", 4, 8'h44, 8'h8A, 8'hFF, 8'hFF);

        // R6 / R8 write of six bytes plus two extra: only one word committed
        saved = mem[7'h41];
        header({3'b0, MY_ID}, 1'b0, 7'h40, 16'd6);
        for (int i = 0; i < 8; i++) txb.push_back(8'(8'h60 + i));
        exp_a_q.push_back(7'h40); exp_d_q.push_back(32'h6362_6160);
        xfer(12);
        drain_check("R8 partial word by length");
        do_read({3'b0, MY_ID}, 7'h41, 16'd4, 4);
        expect_word("R6 partial register unchanged", 4, saved);

        // R9 frame cut after three payload bytes
        saved = mem[7'h50];
        header({3'b0, MY_ID}, 1'b0, 7'h50, 16'd4);
        txb.push_back(8'h91); txb.push_back(8'h92); txb.push_back(8'h93); txb.push_back(8'h94);
        xfer(7);
        header({3'b0, MY_ID}, 1'b0, 7'h50, 16'd4);
        txb.push_back(8'h94);
        xfer(5);
        drain_check("R9 aborted frame no strobe");
        do_read({3'b0, MY_ID}, 7'h50, 16'd4, 4);
        expect_word("R9 aborted register unchanged", 4, saved);

        // R1 foreign ids
        do_read(8'h12, 7'h00, 16'd4, 4);
        expect_bytes("R1 neighbour id silent", 4, 8'hFF, 8'hFF, 8'hFF, 8'hFF);
        do_read({3'b001, MY_ID}, 7'h00, 16'd4, 4);
        expect_bytes("R1 id above range silent", 4, 8'hFF, 8'hFF, 8'hFF, 8'hFF);
        header(8'h12, 1'b0, 7'h22, 16'd4);
        txb.push_back(8'hEE); txb.push_back(8'hEE); txb.push_back(8'hEE); txb.push_back(8'hEE);
        xfer(8);
        drain_check("R1 foreign write no strobe");
        do_read({3'b0, MY_ID}, 7'h22, 16'd4, 4);
        expect_bytes("R1 foreign write no effect", 4, 8'h11, 8'h22, 8'h33, 8'h44);

        // R4 / R5 / R2 writes to internal words
        header({3'b0, MY_ID}, 1'b0, 7'h00, 16'd8);
        for (int i = 0; i < 8; i++) txb.push_back(8'h00);
        xfer(12);
        drain_check("R4 R5 protected write no strobe");
        expect_bytes("R2 write frame miso high", 4, 8'hFF, 8'hFF, 8'hFF, 8'hFF);
        do_read({3'b0, MY_ID}, 7'h00, 16'd8, 8);
        expect_bytes("R4 identification unchanged", 4, 8'h44, 8'h8A, 8'hAC, 8'hB1);
        expect_bytes("R5 status unchanged", 8, 8'h00, 8'h00, 8'(CORES), 8'h00);

        repeat (10) @(posedge clk);
        #1;
        chk(spi_miso == 1'b1, "R9 miso idle after frames", {31'b0, spi_miso}, 1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule